// File: doc/BRIEF.md
# Multi-Mode Instrument Scan Path Router

This block sits between the data-register scan path of a test access port and a bank of `N` embedded instrument shift registers. A select word, loaded from the instruction register or from a local instrument instruction register, names a routing mode and a mode argument. Together they decide which instruments sit between the serial input and the serial output, and in what order. The block drives one select line and one shift enable per instrument. It steers the serial data into each instrument and returns the final serial output.

Four routing modes exist. Single mode places one indexed instrument in the path. Chain mode keeps every instrument segment in the path while the argument marks which are selected. Group mode looks up a fixed instrument set from a parameter table. Accumulate mode treats the argument as one bit per instrument and adds each set bit to the path that is already active. Joined instruments are ordered by ascending index from the serial input to the serial output. An empty path falls back to a one-bit bypass stage, so the output is always driven.

The scan path is paced by the test clock alone and has no back-pressure. Every asserted `shift_en` cycle moves exactly one bit, so no valid/ready handshake exists on the serial stream. The select word is a plain control input.

Top module: `scan_router`

## Requirements
- R1: After the asynchronous reset `trst_n` is low, the path is empty and the mode is accumulate with an all-zero argument. `inst_sel` and `inst_shift` are all zero, and the path behaves as the one-bit bypass.
- R2: The select word `sel_in` is captured only on a falling edge of `tck` while `upd_en` is high. At all other times `inst_sel` and the routing hold their values.
- R3: Single mode (`sel_in[N+1:N]` = 0): the argument `sel_in[N-1:0]` is an instrument index. Only that instrument is selected and in the path. An index of `N` or more selects nothing.
- R4: Chain mode (`sel_in[N+1:N]` = 1): `inst_sel` equals the argument mask, and all `N` instrument segments are in the path.
- R5: Group mode (`sel_in[N+1:N]` = 2): argument bits `[1:0]` pick group g. The members are bits `[g*N +: N]` of `GROUP_MAP`, and only those instruments are selected and in the path.
- R6: Accumulate mode (`sel_in[N+1:N]` = 3): when the previous mode was also accumulate, the new mask is the old mask OR the argument. Otherwise the mask is the argument alone. The mask is both the select set and the path.
- R7: Path instruments are joined in ascending index order. The serial input feeds the lowest in-path index, each in-path instrument feeds the next higher one, and the highest one drives `tdo`.
- R8: With an empty path, `tdo` is a one-bit register that loads `tdi` on each rising `tck` edge with `shift_en` high.
- R9: `inst_shift[i]` is high only while `shift_en` is high and instrument i is in the path. Instruments outside the path keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shifting on rising edge, select update on falling edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data into the routed path |
| shift_en | input | 1 | High during the data-register shift state |
| upd_en | input | 1 | High during an update state; enables select capture |
| sel_in | input | N+2 | Select word: mode in `[N+1:N]`, argument in `[N-1:0]` |
| inst_so | input | N | Serial output of each instrument |
| inst_sel | output | N | Select line per instrument |
| inst_shift | output | N | Shift enable per instrument |
| inst_si | output | N | Serial input steered to each instrument |
| tdo | output | 1 | Serial output of the routed path |

## Verification
The assertions assume that `upd_en` and `shift_en` come from one state machine and change only away from the rising edge. They also assume that `upd_en` is never high while a shift is in progress, so the path cannot change in the middle of a shifted bit. The bench drives both controls just after falling edges. It raises `upd_en` for exactly one cycle between shift bursts. It never overlaps the update strobe with a shift. Each burst first unloads the known preloaded instrument contents and then a marker pattern. This exposes both the order and the length of the path.

// File: rtl/scan_router_pkg.sv
package scan_router_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_GROUP  = 2'd2,
    MODE_ACCUM  = 2'd3
  } route_mode_e;
endpackage

// File: rtl/scan_sel_reg.sv
module scan_sel_reg
  import scan_router_pkg::*;
#(
  parameter int N = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             upd_en,
  input  logic [N+1:0]     sel_in,
  output route_mode_e      mode_q,
  output logic [N-1:0]     arg_q
);
  route_mode_e new_mode;
  assign new_mode = route_mode_e'(sel_in[N+1:N]);

  // selection changes on the falling edge of the update state
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      mode_q <= MODE_ACCUM;
      arg_q  <= '0;
    end else if (upd_en) begin
      mode_q <= new_mode;
      if (new_mode == MODE_ACCUM && mode_q == MODE_ACCUM)
        arg_q <= arg_q | sel_in[N-1:0];
      else
        arg_q <= sel_in[N-1:0];
    end
  end
endmodule

// File: rtl/scan_decode.sv
module scan_decode
  import scan_router_pkg::*;
#(
  parameter int N      = 4,
  parameter int GROUPS = 4,
  parameter logic [GROUPS*N-1:0] GROUP_MAP = 16'h0FA3
) (
  input  route_mode_e  mode,
  input  logic [N-1:0] arg,
  output logic [N-1:0] sel_mask,
  output logic [N-1:0] path_mask
);
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [GW-1:0] grp;
  logic [N-1:0]  single_mask;
  logic [N-1:0]  group_mask;

  assign grp        = arg[GW-1:0];
  assign group_mask = GROUP_MAP[int'(grp)*N +: N];

  always_comb begin
    for (int i = 0; i < N; i++)
      single_mask[i] = (int'(arg) == i);
  end

  always_comb begin
    unique case (mode)
      MODE_SINGLE: begin sel_mask = single_mask; path_mask = single_mask; end
      MODE_CHAIN:  begin sel_mask = arg;         path_mask = '1;          end
      MODE_GROUP:  begin sel_mask = group_mask;  path_mask = group_mask;  end
      default:     begin sel_mask = arg;         path_mask = arg;         end
    endcase
  end
endmodule

// File: rtl/scan_link.sv
module scan_link #(
  parameter int N = 4
) (
  input  logic         tdi,
  input  logic         bypass_q,
  input  logic [N-1:0] path_mask,
  input  logic [N-1:0] inst_so,
  output logic [N-1:0] inst_si,
  output logic         tdo
);
  logic [N:0] link;
  assign link[0] = tdi;

  for (genvar i = 0; i < N; i++) begin : g_hop
    assign inst_si[i]  = link[i];
    assign link[i+1]   = path_mask[i] ? inst_so[i] : link[i];
  end

  assign tdo = (|path_mask) ? link[N] : bypass_q;
endmodule

// File: rtl/scan_router.sv
module scan_router
  import scan_router_pkg::*;
#(
  parameter int N      = 4,
  parameter int GROUPS = 4,
  parameter logic [GROUPS*N-1:0] GROUP_MAP = 16'h0FA3
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         shift_en,
  input  logic         upd_en,
  input  logic [N+1:0] sel_in,
  input  logic [N-1:0] inst_so,
  output logic [N-1:0] inst_sel,
  output logic [N-1:0] inst_shift,
  output logic [N-1:0] inst_si,
  output logic         tdo
);
  route_mode_e  mode_q;
  logic [N-1:0] arg_q;
  logic [N-1:0] path_mask;
  logic         bypass_q;

  scan_sel_reg #(.N(N)) u_sel (
    .tck(tck), .trst_n(trst_n), .upd_en(upd_en), .sel_in(sel_in),
    .mode_q(mode_q), .arg_q(arg_q)
  );

  scan_decode #(.N(N), .GROUPS(GROUPS), .GROUP_MAP(GROUP_MAP)) u_dec (
    .mode(mode_q), .arg(arg_q), .sel_mask(inst_sel), .path_mask(path_mask)
  );

  // one-bit stage used only when no instrument is in the path
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          bypass_q <= 1'b0;
    else if (shift_en && path_mask == '0) bypass_q <= tdi;
  end

  scan_link #(.N(N)) u_link (
    .tdi(tdi), .bypass_q(bypass_q), .path_mask(path_mask),
    .inst_so(inst_so), .inst_si(inst_si), .tdo(tdo)
  );

  assign inst_shift = shift_en ? path_mask : '0;
endmodule

// File: rtl/scan_router_chk.sv
module scan_router_chk #(
  parameter int N = 4
) (
  input logic         tck,
  input logic         trst_n,
  input logic         tdi,
  input logic         shift_en,
  input logic         upd_en,
  input logic [1:0]   mode,
  input logic [N-1:0] inst_sel,
  input logic [N-1:0] inst_shift,
  input logic         tdo
);
  // R9
  shift_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !shift_en |-> inst_shift == '0);

  // R8
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && inst_shift == '0 && !upd_en) |=> tdo == $past(tdi));

  // R2
  sel_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$past(upd_en) |-> $stable(inst_sel));

  // R3
  single_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    mode == 2'd0 |-> $onehot0(inst_sel));

  // R6
  accum_grow_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'd3 && $past(mode) == 2'd3) |-> (inst_sel & $past(inst_sel)) == $past(inst_sel));
endmodule

bind scan_router scan_router_chk #(.N(N)) u_chk (
  .tck(tck), .trst_n(trst_n), .tdi(tdi), .shift_en(shift_en), .upd_en(upd_en),
  .mode(mode_q), .inst_sel(inst_sel), .inst_shift(inst_shift), .tdo(tdo)
);

// File: tb/tb_scan_router.sv
`timescale 1ns/1ps
module tb_scan_router;
  localparam int N = 4;

  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         tdi = 1'b0;
  logic         shift_en = 1'b0;
  logic         upd_en = 1'b0;
  logic [N+1:0] sel_in = '0;
  logic [N-1:0] inst_so;
  logic [N-1:0] inst_sel;
  logic [N-1:0] inst_shift;
  logic [N-1:0] inst_si;
  logic         tdo;
  logic         preload = 1'b0;
  logic         mon_en = 1'b0;
  logic [7:0]   cur [N];
  bit           exp_q [$];
  string        cur_tag = "R1";
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 0;

  always #5 tck = ~tck;

  scan_router dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .shift_en(shift_en), .upd_en(upd_en),
    .sel_in(sel_in), .inst_so(inst_so), .inst_sel(inst_sel),
    .inst_shift(inst_shift), .inst_si(inst_si), .tdo(tdo)
  );

  function automatic int len_of(int i);
    return 3 + i;
  endfunction

  function automatic logic [7:0] pre_val(int i);
    return (8'h5A ^ (8'(i) * 8'h11)) & 8'((1 << len_of(i)) - 1);
  endfunction

  // bench-side instrument shift registers, lengths 3..6
  for (genvar g = 0; g < N; g++) begin : g_inst
    localparam int LG = 3 + g;
    logic [LG-1:0] r;
    always @(posedge tck) begin
      if (preload)            r <= LG'(pre_val(g));
      else if (inst_shift[g]) r <= {inst_si[g], r[LG-1:1]};
    end
    assign inst_so[g] = r[0];
    assign cur[g] = 8'(r);
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard once per shifted bit
  always @(negedge tck) begin
    #3;
    if (mon_en && shift_en && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      check({cur_tag, " tdo"}, 32'(tdo), 32'(e));
    end
  end

  task automatic do_update(logic [N+1:0] s);
    @(negedge tck); #1; sel_in = s; upd_en = 1'b1;
    @(negedge tck); #1; upd_en = 1'b0;
  endtask

  task automatic run_mode(string tag, bit do_upd, logic [N+1:0] s,
                          logic [N-1:0] path, logic [N-1:0] sel_exp);
    logic [15:0] pat;
    int L;
    pat = 16'hB38D;
    cur_tag = tag;
    @(negedge tck); #1; preload = 1'b1;
    @(negedge tck); #1; preload = 1'b0;
    if (do_upd) do_update(s);
    @(negedge tck); #3;
    check({tag, " inst_sel"}, 32'(inst_sel), 32'(sel_exp));
    L = 0;
    exp_q.delete();
    if (path == '0) begin
      // prime the bypass stage with a known zero
      @(negedge tck); #1; tdi = 1'b0; shift_en = 1'b1;
      @(negedge tck); #1; shift_en = 1'b0;
      L = 1;
      exp_q.push_back(1'b0);
    end else begin
      // preloaded contents leave highest index first, bit 0 first (R7)
      for (int i = N - 1; i >= 0; i--) begin
        if (path[i]) begin
          logic [7:0] pv;
          pv = pre_val(i);
          for (int b = 0; b < len_of(i); b++) exp_q.push_back(pv[b]);
          L += len_of(i);
        end
      end
    end
    for (int k = 0; k < 16 + L; k++) begin
      bit b;
      b = (k < 16) ? pat[k] : 1'b0;
      @(negedge tck); #1;
      tdi = b; shift_en = 1'b1; mon_en = 1'b1;
      exp_q.push_back(b);
      if (k == 0) begin
        #2;
        check({tag, " R9 inst_shift"}, 32'(inst_shift), 32'(path));
      end
    end
    @(negedge tck); #1; shift_en = 1'b0; mon_en = 1'b0; tdi = 1'b0;
    exp_q.delete();
    @(negedge tck); #3;
    for (int i = 0; i < N; i++)
      if (!path[i]) check({tag, " R9 kept"}, 32'(cur[i]), 32'(pre_val(i)));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge tck);
    #1; trst_n = 1'b1;
    @(negedge tck); #3;
    // R1 reset state
    check("R1 inst_sel", 32'(inst_sel), 32'(0));
    check("R1 inst_shift", 32'(inst_shift), 32'(0));
    check("R1 tdo", 32'(tdo), 32'(0));
    run_mode("R1", 1'b0, '0, 4'b0000, 4'b0000);
    // R2 select word without update strobe is ignored
    @(negedge tck); #1; sel_in = {2'd0, 4'd2};
    repeat (3) @(negedge tck);
    #3; check("R2 hold", 32'(inst_sel), 32'(0));
    run_mode("R3", 1'b1, {2'd0, 4'd2}, 4'b0100, 4'b0100);
    run_mode("R8", 1'b1, {2'd0, 4'd9}, 4'b0000, 4'b0000);
    run_mode("R4", 1'b1, {2'd1, 4'b0101}, 4'b1111, 4'b0101);
    run_mode("R7", 1'b1, {2'd1, 4'b1111}, 4'b1111, 4'b1111);
    run_mode("R5", 1'b1, {2'd2, 4'd1}, 4'b1010, 4'b1010);
    run_mode("R8", 1'b1, {2'd2, 4'd3}, 4'b0000, 4'b0000);
    do_update({2'd3, 4'b0001});
    run_mode("R6", 1'b1, {2'd3, 4'b0100}, 4'b0101, 4'b0101);
    run_mode("R3", 1'b1, {2'd0, 4'd1}, 4'b0010, 4'b0010);
    run_mode("R6", 1'b1, {2'd3, 4'b0100}, 4'b0100, 4'b0100);
    finish_up();
  end
endmodule